// File: doc/BRIEF.md
# Endpoint DMA Request Handshake Controller

This block raises the DMA request line for the endpoint buffers of a USB device controller. Software writes a single configuration word that holds a transfer-mode bit, a request-enable bit and a 4-bit endpoint code. The block watches the ready flags of endpoints 1 to 5. For an IN endpoint, ready means the buffer has space. For an OUT endpoint, ready means the buffer holds data. The block drives `dreq` toward an external DMA controller and watches that controller's active-low acknowledge, `dack_n`.

There are two request styles. In burst mode the request rises as soon as the enable and the selected buffer allow it. A falling acknowledge drops the request for one cycle only. In one-word mode the request also needs the acknowledge to be idle (high), so each acknowledge pulse ends one request. A new request waits until the acknowledge has returned high. Clearing the enable ends a transfer at once.

`dack_n` passes through a two-flop synchroniser before it is used. `dreq` comes straight from a flop.

Top module: `ep_dreq_ctrl`

## Requirements
- R1: After reset, `dreq` is 0 and a read of the configuration word returns 0.
- R2: A configuration write stores bit 15 as the mode (0 = burst, 1 = one-word), bit 8 as the enable and bits 3:0 as the endpoint code. A read returns those fields in the same positions, and bits 14:9 and 7:4 always read 0.
- R3: A write to any address other than the configuration offset, or a cycle with the write strobe low, leaves the stored configuration and `dreq` unchanged. A read at any other address returns 0.
- R4: `dreq` is 1 only while the stored enable bit is 1.
- R5: Endpoint codes 0 and 6 to 15 never produce a request, whatever the ready flags are.
- R6: For a selected endpoint n (code n, 1 to 5), the ready condition depends on its direction. If `ep_dir_in[n-1]` is 1, the condition is `ep_space[n-1]`; otherwise it is `ep_data[n-1]`. Flags of the other endpoints have no effect.
- R7: In burst mode, `dreq` follows the ready condition one rising edge after the flag changes. Its level does not depend on the level of `dack_n`, so it re-asserts while `dack_n` stays low.
- R8: In one-word mode, `dreq` is 0 whenever the synchronised `dack_n` is low.
- R9: A falling edge on `dack_n` clears `dreq` on the third rising edge after the change, in both modes. In burst mode, `dreq` returns on the next edge if the ready condition still holds.
- R10: In one-word mode, after `dack_n` returns high with the ready condition held, `dreq` re-asserts on the third rising edge.
- R11: A write that clears the enable bit clears `dreq` on the same rising edge that stores the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr_en | input | 1 | Register write strobe |
| cpu_rd_en | input | 1 | Register read strobe |
| cpu_addr | input | 8 | Register word offset |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, 0 when not addressed |
| ep_dir_in | input | 5 | Per-endpoint direction, 1 = IN |
| ep_space | input | 5 | Per-endpoint buffer has room (IN) |
| ep_data | input | 5 | Per-endpoint buffer has data (OUT) |
| dack_n | input | 1 | DMA acknowledge, active low, asynchronous |
| dreq | output | 1 | DMA request, registered |

## Verification
A wrong stored field shows up at the read port on the very next read. It also shows up on `dreq` on the first edge after the write, because the request is computed from the value being written. A stuck or mis-timed synchroniser stage moves the acknowledge reaction off its third-edge slot. That error is visible within three cycles of any `dack_n` change. A wrong mode decode shows in one of two ways. Either a one-cycle gap appears where a long low period is expected, or a request appears while the acknowledge is low. The mode sweep and the acknowledge sequences are built to catch both.

// File: rtl/ep_dreq_pkg.sv
package ep_dreq_pkg;

  localparam int EP_SEL_W = 4;

  typedef enum logic {
    XFER_BURST = 1'b0,
    XFER_WORD  = 1'b1
  } xfer_mode_e;

  typedef struct packed {
    xfer_mode_e          mode;
    logic                en;
    logic [EP_SEL_W-1:0] ep;
  } dma_cfg_t;

endpackage

// File: rtl/ep_dreq_rst_sync.sv
module ep_dreq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ep_dreq_cfg_reg.sv
module ep_dreq_cfg_reg
  import ep_dreq_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h2C,
  parameter int              MODE_BIT = 15,
  parameter int              EN_BIT   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output dma_cfg_t          cfg_q,
  output dma_cfg_t          cfg_nxt
);

  logic     addr_hit;
  logic     wr_hit;
  dma_cfg_t cfg_wr;

  assign addr_hit = (addr == CFG_ADDR);
  assign wr_hit   = wr_en && addr_hit;

  always_comb begin
    cfg_wr.mode = xfer_mode_e'(wdata[MODE_BIT]);
    cfg_wr.en   = wdata[EN_BIT];
    cfg_wr.ep   = wdata[EP_SEL_W-1:0];
  end

  // next-state: forwarded so that the request logic sees a write on its own edge
  always_comb begin
    cfg_nxt = cfg_q;
    if (wr_hit) begin
      cfg_nxt = cfg_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.mode <= XFER_BURST;
      cfg_q.en   <= 1'b0;
      cfg_q.ep   <= '0;
    end else if (wr_hit) begin
      cfg_q <= cfg_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && addr_hit) begin
      rdata[MODE_BIT]         = cfg_q.mode;
      rdata[EN_BIT]           = cfg_q.en;
      rdata[EP_SEL_W-1:0]     = cfg_q.ep;
    end
  end

endmodule

// File: rtl/ep_dreq_dack_sync.sv
module ep_dreq_dack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dack_n_async,
  output logic dack_hi,
  output logic dack_fall
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;
  logic              last_q;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], dack_n_async};
  end

  // idle level of the acknowledge is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_nxt;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign dack_hi   = sync_q[STAGES-1];
  assign dack_fall = last_q && !sync_q[STAGES-1];

endmodule

// File: rtl/ep_dreq_req_gen.sv
module ep_dreq_req_gen
  import ep_dreq_pkg::*;
#(
  parameter int NUM_EP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dma_cfg_t          cfg_nxt,
  input  logic [NUM_EP-1:0] ep_dir_in,
  input  logic [NUM_EP-1:0] ep_space,
  input  logic [NUM_EP-1:0] ep_data,
  input  logic              dack_hi,
  input  logic              dack_fall,
  output logic              dreq
);

  logic [NUM_EP-1:0] ep_hit;
  logic [NUM_EP-1:0] ep_rdy;
  logic              sel_ready;
  logic              armed;
  logic              dreq_q;
  logic              dreq_nxt;

  // endpoint n is addressed by code n; code 0 never matches
  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    assign ep_hit[g] = (cfg_nxt.ep == EP_SEL_W'(g + 1));
    assign ep_rdy[g] = ep_dir_in[g] ? ep_space[g] : ep_data[g];
  end

  assign sel_ready = |(ep_hit & ep_rdy);
  assign armed     = cfg_nxt.en && sel_ready;

  always_comb begin
    unique case (cfg_nxt.mode)
      XFER_BURST: dreq_nxt = armed && !dack_fall;
      XFER_WORD:  dreq_nxt = armed && dack_hi;
      default:    dreq_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_q <= 1'b0;
    end else begin
      dreq_q <= dreq_nxt;
    end
  end

  assign dreq = dreq_q;

endmodule

// File: rtl/ep_dreq_ctrl.sv
module ep_dreq_ctrl
  import ep_dreq_pkg::*;
#(
  parameter int                NUM_EP      = 5,
  parameter int                DATA_W      = 16,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 8'h2C,
  parameter int                MODE_BIT    = 15,
  parameter int                EN_BIT      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic              cpu_rd_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [NUM_EP-1:0] ep_dir_in,
  input  logic [NUM_EP-1:0] ep_space,
  input  logic [NUM_EP-1:0] ep_data,
  input  logic              dack_n,
  output logic              dreq
);

  logic                rst_sync_n;
  dma_cfg_t            cfg_q;
  dma_cfg_t            cfg_nxt;
  logic                dack_hi;
  logic                dack_fall;
  logic                cfg_mode_q;
  logic                cfg_en_q;
  logic [EP_SEL_W-1:0] cfg_ep_q;

  ep_dreq_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ep_dreq_cfg_reg #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CFG_ADDR (CFG_ADDR),
    .MODE_BIT (MODE_BIT),
    .EN_BIT   (EN_BIT)
  ) cfg_reg_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cpu_wr_en),
    .rd_en   (cpu_rd_en),
    .addr    (cpu_addr),
    .wdata   (cpu_wdata),
    .rdata   (cpu_rdata),
    .cfg_q   (cfg_q),
    .cfg_nxt (cfg_nxt)
  );

  ep_dreq_dack_sync #(.STAGES(SYNC_STAGES)) dack_sync_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .dack_n_async (dack_n),
    .dack_hi      (dack_hi),
    .dack_fall    (dack_fall)
  );

  ep_dreq_req_gen #(.NUM_EP(NUM_EP)) req_gen_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_nxt   (cfg_nxt),
    .ep_dir_in (ep_dir_in),
    .ep_space  (ep_space),
    .ep_data   (ep_data),
    .dack_hi   (dack_hi),
    .dack_fall (dack_fall),
    .dreq      (dreq)
  );

  assign cfg_mode_q = cfg_q.mode;
  assign cfg_en_q   = cfg_q.en;
  assign cfg_ep_q   = cfg_q.ep;

endmodule

// File: rtl/ep_dreq_chk.sv
module ep_dreq_chk #(
  parameter int                NUM_EP   = 5,
  parameter int                DATA_W   = 16,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h2C,
  parameter int                EN_BIT   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dreq,
  input logic              cfg_mode,
  input logic              cfg_en,
  input logic [3:0]        cfg_ep,
  input logic              dack_hi,
  input logic              dack_fall,
  input logic              cpu_wr_en,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata
);

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> cfg_en); // R4

  AST_EP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> (cfg_ep != 4'd0 && cfg_ep <= 4'(NUM_EP))); // R5

  AST_WORD_NEEDS_DACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && $rose(dreq)) |-> $past(dack_hi)); // R8

  AST_FALL_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dack_fall |=> !dreq); // R9

  AST_EN_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && cpu_addr == CFG_ADDR && !cpu_wdata[EN_BIT]) |=> !dreq); // R11

  AST_OTHER_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && cpu_addr != CFG_ADDR) |=> $stable({cfg_mode, cfg_en, cfg_ep})); // R3

endmodule

bind ep_dreq_ctrl ep_dreq_chk #(
  .NUM_EP   (NUM_EP),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .CFG_ADDR (CFG_ADDR),
  .EN_BIT   (EN_BIT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .dreq      (dreq),
  .cfg_mode  (cfg_mode_q),
  .cfg_en    (cfg_en_q),
  .cfg_ep    (cfg_ep_q),
  .dack_hi   (dack_hi),
  .dack_fall (dack_fall),
  .cpu_wr_en (cpu_wr_en),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata)
);

// File: tb/ep_dreq_ctrl_tb.sv
`timescale 1ns/100ps
module ep_dreq_ctrl_tb_top;

  localparam logic [7:0] CFG = 8'h2C;

  logic        clk;
  logic        rst_n;
  logic        cpu_wr_en;
  logic        cpu_rd_en;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic [15:0] cpu_rdata;
  logic [4:0]  ep_dir_in;
  logic [4:0]  ep_space;
  logic [4:0]  ep_data;
  logic        dack_n;
  logic        dreq;

  int checks;
  int failures;
  bit done;

  ep_dreq_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr_en (cpu_wr_en),
    .cpu_rd_en (cpu_rd_en),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .ep_dir_in (ep_dir_in),
    .ep_space  (ep_space),
    .ep_data   (ep_data),
    .dack_n    (dack_n),
    .dreq      (dreq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    cpu_wr_en = 1'b1;
    cpu_addr  = a;
    cpu_wdata = d;
    tick();
    cpu_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    cpu_rd_en = 1'b1;
    cpu_addr  = a;
    #1;
    d = cpu_rdata;
    cpu_rd_en = 1'b0;
  endtask

  function automatic logic [15:0] cfg_word(input bit mode, input bit en, input logic [3:0] ep);
    return {mode, 6'b0, en, 4'b0, ep};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] rv;
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; cpu_wr_en = 1'b0; cpu_rd_en = 1'b0;
    cpu_addr = '0; cpu_wdata = '0;
    ep_dir_in = '1; ep_space = '1; ep_data = '1; dack_n = 1'b1;
    repeat (3) tick();
    check("R1 dreq in reset", dreq, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check("R1 dreq after reset", dreq, 0);
    rd(CFG, rv);
    check("R1 readback after reset", rv, 16'h0000);

    // R2: field positions and reserved bits
    wr(CFG, 16'hFFFF);
    rd(CFG, rv);
    check("R2 all ones readback", rv, 16'h810F);
    wr(CFG, 16'h7EF0);
    rd(CFG, rv);
    check("R2 reserved only readback", rv, 16'h0000);
    wr(CFG, 16'h8105);
    rd(CFG, rv);
    check("R2 word mode ep5 readback", rv, 16'h8105);

    // R3: other address and idle strobe ignored
    wr(CFG, cfg_word(0, 1, 4'd2));
    check("R3 baseline dreq", dreq, 1);
    wr(CFG + 8'h4, 16'h0000);
    check("R3 other-address write dreq", dreq, 1);
    rd(CFG, rv);
    check("R3 other-address write readback", rv, 16'h0102);
    cpu_addr = CFG; cpu_wdata = 16'h0000; tick();
    check("R3 no-strobe dreq", dreq, 1);
    rd(CFG, rv);
    check("R3 no-strobe readback", rv, 16'h0102);
    rd(CFG + 8'h1, rv);
    check("R3 read other address", rv, 16'h0000);

    // sweep: R4 R5 R6 with idle acknowledge, both modes (R8 idle case)
    for (int mode = 0; mode < 2; mode++) begin
      for (int en = 0; en < 2; en++) begin
        for (int ep = 0; ep < 16; ep++) begin
          for (int pat = 0; pat < 8; pat++) begin
            logic [4:0] m;
            bit exp;
            m = (ep >= 1 && ep <= 5) ? 5'(1 << (ep - 1)) : 5'b0;
            ep_dir_in = pat[0] ? m : ~m;
            ep_space  = pat[1] ? m : ~m;
            ep_data   = pat[2] ? m : ~m;
            wr(CFG, cfg_word(mode[0], en[0], 4'(ep)));
            exp = (en == 1) && (ep >= 1) && (ep <= 5) && (pat[0] ? pat[1] : pat[2]);
            check($sformatf("R4 R5 R6 sweep mode=%0d en=%0d ep=%0d pat=%0d", mode, en, ep, pat),
                  dreq, exp);
          end
        end
      end
    end

    // R7: burst follows ready one edge later
    ep_dir_in = 5'b00100; ep_space = 5'b00100; ep_data = 5'b00000;
    wr(CFG, cfg_word(0, 1, 4'd3));
    check("R7 burst ready", dreq, 1);
    ep_space = 5'b00000;
    #1 check("R7 burst before edge", dreq, 1);
    tick();
    check("R7 burst after ready drop", dreq, 0);
    ep_space = 5'b00100;
    tick();
    check("R7 burst after ready rise", dreq, 1);

    // R9 burst: falling acknowledge gives one-cycle gap, then R7 re-assert while low
    dack_n = 1'b0;
    tick(); tick();
    check("R9 burst before third edge", dreq, 1);
    tick();
    check("R9 burst third edge drop", dreq, 0);
    tick();
    check("R7 burst reassert with ack low", dreq, 1);
    tick();
    check("R7 burst stays with ack low", dreq, 1);
    dack_n = 1'b1;
    repeat (4) tick();
    check("R7 burst ack return", dreq, 1);

    // one-word mode
    wr(CFG, cfg_word(1, 1, 4'd3));
    check("R8 word idle ack", dreq, 1);
    dack_n = 1'b0;
    tick(); tick();
    check("R9 word before third edge", dreq, 1);
    tick();
    check("R9 word third edge drop", dreq, 0);
    repeat (3) tick();
    check("R8 word held low ack", dreq, 0);
    dack_n = 1'b1;
    tick(); tick();
    check("R10 word before third edge", dreq, 0);
    tick();
    check("R10 word reassert", dreq, 1);

    // R8: entering one-word mode with acknowledge already low
    dack_n = 1'b0;
    repeat (4) tick();
    wr(CFG, cfg_word(1, 1, 4'd3));
    check("R8 word enable with ack low", dreq, 0);
    wr(CFG, cfg_word(0, 1, 4'd3));
    check("R7 burst enable with ack low", dreq, 1);
    dack_n = 1'b1;
    repeat (4) tick();

    // R11: clearing enable drops on the write edge
    check("R11 precondition", dreq, 1);
    wr(CFG, cfg_word(0, 0, 4'd3));
    check("R11 burst enable clear", dreq, 0);
    wr(CFG, cfg_word(1, 1, 4'd3));
    check("R11 word re-enable", dreq, 1);
    wr(CFG, cfg_word(1, 0, 4'd3));
    check("R11 word enable clear", dreq, 0);
    tick();
    check("R11 stays low", dreq, 0);

    finish_run();
  end

endmodule